// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a shared packet memory cut into 256-byte pages. A host drives it with one-byte commands. The top three bits of a command pick an operation, and the low five bits give the page count for an allocation. The block hands out packet numbers and tracks how many pages each one holds. It keeps a count of free pages and runs two queues of packet numbers, one for receive and one for transmit. The packet RAM itself, the MAC and the bus bridge sit outside the block. The receive path loads its queue through a one-cycle strobe that carries a packet number.

An allocation takes the lowest packet number not in use. It fails when the free pages, less a transmit reservation set by a 5-bit input, cannot cover the request, or when every packet number is already in use. The result byte flags a failure in bit 7. A command that frees pages raises a busy flag for a fixed window. The queue heads and the page counts come out in register-shaped words, so a bus bridge can map them straight onto host registers.

Top module: `pkt_page_alloc`

## Requirements
- R1: A command is taken when `cmd_valid_i` is high. Bits 7:5 select the operation: 0 no-op, 1 allocate, 2 reset state, 3 remove the receive head, 4 release the receive head, 5 free the packet given by `pnr_i`, 6 enqueue for transmit, 7 clear the transmit queue. A no-op changes no output.
- R2: An allocate requests (bits 4:0 + 1) pages. On success the lowest unused packet number is granted, `alloc_res_o` becomes {0, number}, and the free count drops by the request, all one cycle after the command.
- R3: An allocate fails when the request exceeds the free pages minus `tx_rsv_i` (taken as 0 when the reservation is at least the free count). A failure sets `alloc_res_o` to 0x80 and leaves the free count unchanged.
- R4: An allocate fails with 0x80 when all packet numbers are in use, even if pages remain.
- R5: A free command (5) returns the recorded pages of packet `pnr_i` and marks the number unused. A number that is not allocated is ignored.
- R6: `busy_o` is high for exactly 4 cycles, starting the cycle after a command 4 or 5.
- R7: `qhead_o` holds {rx_empty, rx_head[6:0], tx_empty, tx_head[6:0]}. A head reads 0 when its queue is empty.
- R8: `rx_push_i` appends `rx_pkt_i` to the receive queue. Command 3 drops the receive head without freeing it. Command 3 or 4 on an empty queue does nothing.
- R9: Command 4 drops the receive head and returns that packet's pages to the free count.
- R10: Command 6 appends `pnr_i` to the transmit queue. Command 7 empties the transmit queue.
- R11: Each queue holds 16 entries. A push into a full queue is dropped.
- R12: `mem_info_o` is {free_pages, total_pages}. Both `rst_ni` low and command 2 leave all pages free, both queues empty, every number unused, `alloc_res_o` at 0x80 and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command word: opcode in 7:5, page count minus one in 4:0 |
| pnr_i | input | 7 | Packet number used by the free and enqueue commands |
| tx_rsv_i | input | 5 | Pages held back from allocation for transmit |
| rx_push_i | input | 1 | Receive enqueue strobe |
| rx_pkt_i | input | 7 | Packet number to append to the receive queue |
| alloc_res_o | output | 8 | Allocation result: bit 7 failed, 6:0 packet number |
| busy_o | output | 1 | Release in progress |
| qhead_o | output | 16 | Queue heads and empty flags |
| mem_info_o | output | 16 | Free pages (high byte), total pages (low byte) |

## Verification
The bench builds the block with its default parameters: 32 pages, 16 packet numbers and 16-entry queues. With 16 packet numbers the number pool runs dry after a short sequence of single-page allocations, while pages are still left over. That isolates the failure caused by running out of numbers from the failure caused by running out of pages. A 32-page memory lets the transmit reservation, set near the free count, block a request that would otherwise fit. The 16-entry depth lets the bench push past full and then drain the queue, which shows that the dropped entry never appears.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
  localparam int PN_W = 7;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_REMOVE  = 3'd3,
    OP_RELEASE = 3'd4,
    OP_FREE    = 3'd5,
    OP_ENQ     = 3'd6,
    OP_TXRST   = 3'd7
  } op_e;

  localparam logic [7:0] RES_FAIL = 8'h80;
endpackage

// File: rtl/pkt_num_fifo.sv
module pkt_num_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  // R11: a push into a full queue leaves the occupancy unchanged
  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !clear_i) |=> $stable(cnt_q));
  // R8: a pop from an empty queue leaves it empty
  a_r8_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clear_i) |=> empty_o);
endmodule

// File: rtl/pkt_page_ledger.sv
module pkt_page_ledger
  import pkt_alloc_pkg::*;
#(
  parameter int TOTAL_PAGES = 32,
  parameter int NUM_PKTS    = 16,
  parameter int REQ_W       = 5,
  parameter int RSV_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             alloc_i,
  input  logic [REQ_W-1:0] size_m1_i,
  input  logic             free_i,
  input  logic [PN_W-1:0]  free_num_i,
  input  logic [RSV_W-1:0] tx_rsv_i,
  output logic [7:0]       free_pages_o,
  output logic [7:0]       alloc_res_o
);
  localparam int NUM_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
  localparam int PG_W  = 8;

  logic [PG_W-1:0]   free_q;
  logic [NUM_PKTS-1:0] used_q;
  logic [PG_W-1:0]   pages_q [NUM_PKTS];
  logic [7:0]        res_q;

  logic [PG_W-1:0]  req, rsv, avail;
  logic             any_unused, fail;
  logic [NUM_W-1:0] pick;
  logic [NUM_W-1:0] fidx;
  logic             free_hit;

  assign req   = PG_W'(size_m1_i) + 1'b1;
  assign rsv   = PG_W'(tx_rsv_i);
  assign avail = (free_q > rsv) ? (free_q - rsv) : '0;

  always_comb begin
    any_unused = 1'b0;
    pick       = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        any_unused = 1'b1;
        pick       = NUM_W'(i);
      end
    end
  end

  assign fail     = (req > avail) || !any_unused;
  assign fidx     = free_num_i[NUM_W-1:0];
  assign free_hit = free_i && (free_num_i < PN_W'(NUM_PKTS)) && used_q[fidx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= PG_W'(TOTAL_PAGES);
      used_q <= '0;
      res_q  <= RES_FAIL;
    end else if (clear_i) begin
      free_q <= PG_W'(TOTAL_PAGES);
      used_q <= '0;
      res_q  <= RES_FAIL;
    end else if (alloc_i) begin
      if (fail) begin
        res_q <= RES_FAIL;
      end else begin
        res_q        <= {1'b0, PN_W'(pick)};
        used_q[pick] <= 1'b1;
        free_q       <= free_q - req;
      end
    end else if (free_hit) begin
      used_q[fidx] <= 1'b0;
      free_q       <= free_q + pages_q[fidx];
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i && !fail && !clear_i) pages_q[pick] <= req;
  end

  assign free_pages_o = free_q;
  assign alloc_res_o  = res_q;

  // R12: free count never exceeds the memory size
  a_r12_free_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= PG_W'(TOTAL_PAGES));
  // R3: a failed allocation leaves the free count alone
  a_r3_fail_keeps_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !clear_i && (req > avail)) |=> (res_q == RES_FAIL) && $stable(free_q));
  // R2: a granted allocation lowers the free count
  a_r2_grant_takes_pages: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !clear_i && !fail) |=> (free_q < $past(free_q)) && !res_q[7]);
  // R4: no grant when the number pool is exhausted
  a_r4_pool_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !clear_i && (&used_q)) |=> res_q[7]);
endmodule

// File: rtl/pkt_busy_timer.sv
module pkt_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R6: a release raises busy on the next cycle
  a_r6_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i) |=> busy_o);
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_alloc_pkg::*;
#(
  parameter int TOTAL_PAGES = 32,
  parameter int NUM_PKTS    = 16,
  parameter int Q_DEPTH     = 16,
  parameter int BUSY_CYC    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [7:0]      cmd_i,
  input  logic [PN_W-1:0] pnr_i,
  input  logic [4:0]      tx_rsv_i,
  input  logic            rx_push_i,
  input  logic [PN_W-1:0] rx_pkt_i,
  output logic [7:0]      alloc_res_o,
  output logic            busy_o,
  output logic [15:0]     qhead_o,
  output logic [15:0]     mem_info_o
);
  localparam int REQ_W = 5;

  op_e op;
  logic is_alloc, is_reset, is_remove, is_release, is_free, is_enq, is_txrst;
  logic [PN_W-1:0] rx_head, tx_head, free_num;
  logic rx_empty, tx_empty, free_req;
  logic [7:0] free_pages;

  assign op         = op_e'(cmd_i[7:5]);
  assign is_alloc   = cmd_valid_i && (op == OP_ALLOC);
  assign is_reset   = cmd_valid_i && (op == OP_RESET);
  assign is_remove  = cmd_valid_i && (op == OP_REMOVE);
  assign is_release = cmd_valid_i && (op == OP_RELEASE);
  assign is_free    = cmd_valid_i && (op == OP_FREE);
  assign is_enq     = cmd_valid_i && (op == OP_ENQ);
  assign is_txrst   = cmd_valid_i && (op == OP_TXRST);

  assign free_req = (is_release && !rx_empty) || is_free;
  assign free_num = is_release ? rx_head : pnr_i;

  pkt_num_fifo #(.DEPTH(Q_DEPTH), .W(PN_W)) u_rxq (
    .clk_i, .rst_ni,
    .clear_i (is_reset),
    .push_i  (rx_push_i),
    .data_i  (rx_pkt_i),
    .pop_i   (is_remove || is_release),
    .head_o  (rx_head),
    .empty_o (rx_empty)
  );

  pkt_num_fifo #(.DEPTH(Q_DEPTH), .W(PN_W)) u_txq (
    .clk_i, .rst_ni,
    .clear_i (is_reset || is_txrst),
    .push_i  (is_enq),
    .data_i  (pnr_i),
    .pop_i   (1'b0),
    .head_o  (tx_head),
    .empty_o (tx_empty)
  );

  pkt_page_ledger #(
    .TOTAL_PAGES(TOTAL_PAGES), .NUM_PKTS(NUM_PKTS), .REQ_W(REQ_W), .RSV_W(5)
  ) u_ledger (
    .clk_i, .rst_ni,
    .clear_i      (is_reset),
    .alloc_i      (is_alloc),
    .size_m1_i    (cmd_i[REQ_W-1:0]),
    .free_i       (free_req),
    .free_num_i   (free_num),
    .tx_rsv_i     (tx_rsv_i),
    .free_pages_o (free_pages),
    .alloc_res_o  (alloc_res_o)
  );

  pkt_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni,
    .clear_i (is_reset),
    .start_i (is_release || is_free),
    .busy_o  (busy_o)
  );

  assign qhead_o    = {rx_empty, rx_head, tx_empty, tx_head};
  assign mem_info_o = {free_pages, 8'(TOTAL_PAGES)};

  // R12: the reset command empties both queues and restores all pages
  a_r12_reset_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reset |=> (qhead_o == 16'h8080) && (mem_info_o[15:8] == 8'(TOTAL_PAGES)));
  // R10: clearing the transmit queue leaves it empty
  a_r10_txrst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_txrst |=> qhead_o[7]);
  // R9: releasing a non-empty head never lowers the free count
  a_r9_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_release && !rx_empty) |=> mem_info_o[15:8] >= $past(mem_info_o[15:8]));
endmodule

// File: tb/pkt_page_alloc_test.sv
module pkt_page_alloc_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd = '0;
  logic [6:0] pnr = '0, rx_pkt = '0;
  logic [4:0] tx_rsv = '0;
  logic rx_push = 1'b0;
  logic [7:0] alloc_res;
  logic busy;
  logic [15:0] qhead, mem_info;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_page_alloc uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .pnr_i(pnr), .tx_rsv_i(tx_rsv), .rx_push_i(rx_push), .rx_pkt_i(rx_pkt),
    .alloc_res_o(alloc_res), .busy_o(busy), .qhead_o(qhead), .mem_info_o(mem_info)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // issue one command; returns at the negedge after it took effect
  task automatic issue(input logic [2:0] op, input logic [4:0] arg, input logic [6:0] num);
    @(negedge clk);
    cmd = {op, arg}; pnr = num; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = '0;
  endtask

  task automatic rx_in(input logic [6:0] num);
    @(negedge clk);
    rx_push = 1'b1; rx_pkt = num;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic t_reset_state;
    check("R12 reset mem_info", mem_info, 16'h2020);
    check("R7 reset qhead", qhead, 16'h8080);
    check("R12 reset result", {8'h0, alloc_res}, 16'h0080);
    check("R12 reset busy", {15'h0, busy}, 16'h0);
  endtask

  task automatic t_alloc;
    issue(3'd1, 5'd2, 7'd0);
    check("R2 first grant", {8'h0, alloc_res}, 16'h0000);
    check("R2 free after 3 pages", mem_info, 16'h1D20);
    issue(3'd1, 5'd7, 7'd0);
    check("R2 second grant", {8'h0, alloc_res}, 16'h0001);
    check("R2 free after 8 pages", mem_info, 16'h1520);
  endtask

  task automatic t_reserve;
    tx_rsv = 5'd20;
    issue(3'd1, 5'd1, 7'd0);
    check("R3 reserve blocks", {8'h0, alloc_res}, 16'h0080);
    check("R3 free kept", mem_info, 16'h1520);
    issue(3'd1, 5'd0, 7'd0);
    check("R3 fits reserve", {8'h0, alloc_res}, 16'h0002);
    issue(3'd1, 5'd0, 7'd0);
    check("R3 reserve equals free", {8'h0, alloc_res}, 16'h0080);
    check("R3 free kept 2", mem_info, 16'h1420);
    tx_rsv = 5'd0;
  endtask

  task automatic t_pool;
    for (int i = 3; i < 16; i++) issue(3'd1, 5'd0, 7'd0);
    check("R2 last grant", {8'h0, alloc_res}, 16'h000F);
    check("R4 free before", mem_info, 16'h0720);
    issue(3'd1, 5'd0, 7'd0);
    check("R4 pool exhausted", {8'h0, alloc_res}, 16'h0080);
    check("R4 free kept", mem_info, 16'h0720);
  endtask

  task automatic t_free;
    issue(3'd5, 5'd0, 7'd1);
    check("R5 free pkt 1", mem_info, 16'h0F20);
    check("R6 busy start", {15'h0, busy}, 16'h1);
    repeat (3) @(negedge clk);
    check("R6 busy cycle 4", {15'h0, busy}, 16'h1);
    @(negedge clk);
    check("R6 busy end", {15'h0, busy}, 16'h0);
    issue(3'd1, 5'd0, 7'd0);
    check("R2 lowest unused", {8'h0, alloc_res}, 16'h0001);
    check("R2 free after reuse", mem_info, 16'h0E20);
    issue(3'd5, 5'd0, 7'd1);
    check("R5 free again", mem_info, 16'h0F20);
    issue(3'd5, 5'd0, 7'd1);
    check("R5 unused ignored", mem_info, 16'h0F20);
  endtask

  task automatic t_rxq;
    rx_in(7'd0);
    rx_in(7'd2);
    check("R8 rx head", qhead, 16'h0080);
    issue(3'd3, 5'd0, 7'd0);
    check("R8 remove advances", qhead, 16'h0280);
    check("R8 remove keeps pages", mem_info, 16'h0F20);
    issue(3'd4, 5'd0, 7'd0);
    check("R9 release empties", qhead, 16'h8080);
    check("R9 release frees", mem_info, 16'h1020);
    issue(3'd3, 5'd0, 7'd0);
    check("R8 remove on empty", qhead, 16'h8080);
    issue(3'd4, 5'd0, 7'd0);
    check("R8 release on empty", mem_info, 16'h1020);
  endtask

  task automatic t_txq;
    issue(3'd6, 5'd0, 7'd5);
    issue(3'd6, 5'd0, 7'd7);
    check("R10 tx head", qhead, 16'h8005);
    issue(3'd7, 5'd0, 7'd0);
    check("R10 tx cleared", qhead, 16'h8080);
  endtask

  task automatic t_depth;
    for (int i = 0; i < 17; i++) rx_in(7'(i + 32));
    for (int i = 0; i < 16; i++) begin
      check("R11 drain order", {8'h0, qhead[15:8]}, 16'(i + 32));
      issue(3'd3, 5'd0, 7'd0);
    end
    check("R11 overflow dropped", qhead, 16'h8080);
  endtask

  task automatic t_nop;
    issue(3'd0, 5'd3, 7'd3);
    check("R1 nop mem", mem_info, 16'h1020);
    check("R1 nop qhead", qhead, 16'h8080);
  endtask

  task automatic t_reset_cmd;
    rx_in(7'd9);
    issue(3'd6, 5'd0, 7'd4);
    issue(3'd2, 5'd0, 7'd0);
    check("R12 reset cmd mem", mem_info, 16'h2020);
    check("R12 reset cmd qhead", qhead, 16'h8080);
    check("R12 reset cmd result", {8'h0, alloc_res}, 16'h0080);
    issue(3'd1, 5'd0, 7'd0);
    check("R12 numbers freed", {8'h0, alloc_res}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_alloc();
    t_reserve();
    t_pool();
    t_free();
    t_rxq();
    t_txq();
    t_depth();
    t_nop();
    t_reset_cmd();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule